// File: doc/BRIEF.md
# Spare Area Section Remapper

This engine moves the out-of-band bytes of a flash page between two layouts. The controller's spare RAM keeps one slot per 512-byte main sector, each slot at a fixed stride. The page buffer keeps the same bytes as one contiguous run placed directly after the page's main data. On a page read the engine gathers the spare slots into the contiguous run. On a page program it scatters the run back into the slots.

A pulse on `start` latches the direction, the page size and the OOB size, and the copy runs on its own. The engine reads one byte per clock from the source RAM and writes it to the destination RAM on the next clock. `done` pulses once after the last byte has been written. Both RAMs are byte wide and have one cycle of read latency.

Top module: `nandSpareRemap`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `spareWe` and `bufWe` are low.
- R2: The section count n equals `pageSize`/512. `pageSize` must be a power of two from 512 up to MAX_SECT*512.
- R3: Every section except the last holds L bytes, where L is `oobSize`/n rounded down to an even number. When L is 0, every byte belongs to the last section.
- R4: The last section holds the bytes left over, `oobSize` - (n-1)*L. It may be longer than L.
- R5: Byte k of section i sits in the spare RAM at address i*STRIDE + k. STRIDE is a parameter with a default of 16.
- R6: Byte k of section i sits in the page buffer at address `pageSize` + i*L + k. The run is contiguous and increasing.
- R7: With `dirScatter`=0 (gather), the engine reads the spare RAM and writes the page buffer. With `dirScatter`=1 (scatter), it reads the page buffer and writes the spare RAM.
- R8: The engine moves one byte per clock in increasing section order and, inside each section, in increasing offset order. Each destination write carries the byte read at the matching source address one cycle earlier.
- R9: `done` is high for exactly one cycle, and that cycle comes right after the cycle of the last write. A transfer of N>0 bytes puts `done` N+2 cycles after the cycle in which `start` is sampled. With `oobSize`=0, no write happens and `done` comes in the next cycle.
- R10: While a transfer is active, through the cycle in which `done` is high, `start` and changes on `dirScatter`, `pageSize` and `oobSize` have no effect. No write occurs outside a transfer.
- R11: Only the destination port writes, and `spareWe` and `bufWe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer when idle |
| dirScatter | input | 1 | 0 = gather into the page buffer, 1 = scatter into the spare RAM |
| pageSize | input | 12 | Main page size in bytes |
| oobSize | input | 7 | OOB byte count |
| done | output | 1 | One-cycle completion pulse |
| spareAddr | output | 7 | Spare RAM address |
| spareWdata | output | 8 | Spare RAM write data |
| spareWe | output | 1 | Spare RAM write enable |
| spareRdata | input | 8 | Spare RAM read data (one-cycle latency) |
| bufAddr | output | 12 | Page buffer address |
| bufWdata | output | 8 | Page buffer write data |
| bufWe | output | 1 | Page buffer write enable |
| bufRdata | input | 8 | Page buffer read data (one-cycle latency) |

## Verification
The hardest cases to reach are the ones where the section lengths are uneven. The bench picks OOB sizes that force them. One is an odd total, where the last section is longer than the stride and runs past its slot. Another is a total smaller than twice the section count, which collapses every byte into the final section at the top slot. A third case raises `start` in the middle of a run and changes every mode input at the same time. The scoreboard then requires the remaining writes to follow the original parameters and forbids any write after `done`.

// File: rtl/spareRemapPkg.sv
package spareRemapPkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // latch mode inputs, clear counters
    logic step;   // issue one source read, advance counters
    logic wrEn;   // write the byte read in the previous cycle
  } remapStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_DONE
  } remapState_t;

endpackage

// File: rtl/spareRemapCtrl.sv
module spareRemapCtrl
  import spareRemapPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         oobZero,
  input  logic         lastByte,
  output remapStrobe_t strobe,
  output logic         done,
  output logic         busy
);

  remapState_t state, stateNext;
  logic        wrEnQ;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (start) stateNext = oobZero ? ST_DONE : ST_RUN;
      ST_RUN:  if (lastByte) stateNext = ST_TAIL;
      ST_TAIL: stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wrEnQ <= 1'b0;
    end else begin
      state <= stateNext;
      wrEnQ <= (state == ST_RUN);
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    strobe.wrEn = wrEnQ;
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/spareRemapPath.sv
module spareRemapPath
  import spareRemapPkg::*;
#(
  parameter int MAX_SECT   = 4,
  parameter int STRIDE     = 16,
  parameter int SECT_BYTES = 512,
  parameter int PAGE_W     = $clog2(MAX_SECT * SECT_BYTES) + 1,
  parameter int OOB_W      = $clog2(MAX_SECT * STRIDE) + 1,
  parameter int SPARE_AW   = $clog2(MAX_SECT * STRIDE) + 1,
  parameter int BUF_AW     = $clog2(MAX_SECT * SECT_BYTES + 2 * MAX_SECT * STRIDE)
) (
  input  logic                clk,
  input  logic                rstN,
  input  remapStrobe_t        strobe,
  input  logic                dirScatter,
  input  logic [PAGE_W-1:0]   pageSize,
  input  logic [OOB_W-1:0]    oobSize,
  output logic                oobZero,
  output logic                lastByte,
  output logic [SPARE_AW-1:0] spareAddr,
  output logic [7:0]          spareWdata,
  output logic                spareWe,
  input  logic [7:0]          spareRdata,
  output logic [BUF_AW-1:0]   bufAddr,
  output logic [7:0]          bufWdata,
  output logic                bufWe,
  input  logic [7:0]          bufRdata
);

  localparam int SECT_SHIFT = $clog2(SECT_BYTES);
  localparam int SEC_W      = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1;
  localparam int LG_W       = $clog2(SEC_W + 1) + 1;

  // ---- decode of the mode inputs (used only at load) ----
  logic [PAGE_W-1:0] inSecCnt;
  logic [LG_W-1:0]   inLg;
  logic [SEC_W-1:0]  inLastSec;
  logic [OOB_W-1:0]  inLen;
  logic [OOB_W-1:0]  inLastLen;
  logic [SEC_W-1:0]  inStartSec;

  always_comb begin
    inSecCnt = pageSize >> SECT_SHIFT;
    inLg     = '0;
    for (int j = 0; j <= SEC_W; j++) begin
      if (inSecCnt[j]) inLg = LG_W'(j);
    end
    inLastSec  = SEC_W'(inSecCnt - 1'b1);
    inLen      = (oobSize >> (inLg + 1'b1)) << 1;
    inLastLen  = oobSize - OOB_W'(inLastSec) * inLen;
    inStartSec = (inLen == '0) ? inLastSec : '0;
  end

  assign oobZero = (oobSize == '0);

  // ---- latched transfer state ----
  logic [SEC_W-1:0]    lastSecQ, secQ;
  logic [OOB_W-1:0]    lenQ, lastLenQ, offQ, idxQ;
  logic [PAGE_W-1:0]   pageQ;
  logic                dirQ;
  logic [SPARE_AW-1:0] prevSpareQ;
  logic [BUF_AW-1:0]   prevArrQ;

  logic [OOB_W-1:0]    curLen;
  logic [SPARE_AW-1:0] curSpare;
  logic [BUF_AW-1:0]   curArr;
  logic                secEnd;

  always_comb begin
    curLen   = (secQ == lastSecQ) ? lastLenQ : lenQ;
    secEnd   = (offQ == curLen - 1'b1);
    lastByte = (secQ == lastSecQ) && secEnd;
    curSpare = SPARE_AW'(secQ) * SPARE_AW'(STRIDE) + SPARE_AW'(offQ);
    curArr   = BUF_AW'(pageQ) + BUF_AW'(idxQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSecQ   <= '0;
      secQ       <= '0;
      lenQ       <= '0;
      lastLenQ   <= '0;
      offQ       <= '0;
      idxQ       <= '0;
      pageQ      <= '0;
      dirQ       <= 1'b0;
      prevSpareQ <= '0;
      prevArrQ   <= '0;
    end else if (strobe.load) begin
      lastSecQ <= inLastSec;
      secQ     <= inStartSec;
      lenQ     <= inLen;
      lastLenQ <= inLastLen;
      offQ     <= '0;
      idxQ     <= '0;
      pageQ    <= pageSize;
      dirQ     <= dirScatter;
    end else if (strobe.step) begin
      prevSpareQ <= curSpare;
      prevArrQ   <= curArr;
      idxQ       <= idxQ + 1'b1;
      if (secEnd) begin
        secQ <= secQ + 1'b1;
        offQ <= '0;
      end else begin
        offQ <= offQ + 1'b1;
      end
    end
  end

  // ---- port steering: source port reads current, destination writes previous ----
  always_comb begin
    spareAddr  = dirQ ? prevSpareQ : curSpare;
    bufAddr    = dirQ ? curArr : prevArrQ;
    spareWe    = strobe.wrEn && dirQ;
    bufWe      = strobe.wrEn && !dirQ;
    spareWdata = bufRdata;
    bufWdata   = spareRdata;
  end

endmodule

// File: rtl/nandSpareRemap.sv
module nandSpareRemap
  import spareRemapPkg::*;
#(
  parameter int MAX_SECT   = 4,
  parameter int STRIDE     = 16,
  parameter int SECT_BYTES = 512,
  parameter int PAGE_W     = $clog2(MAX_SECT * SECT_BYTES) + 1,
  parameter int OOB_W      = $clog2(MAX_SECT * STRIDE) + 1,
  parameter int SPARE_AW   = $clog2(MAX_SECT * STRIDE) + 1,
  parameter int BUF_AW     = $clog2(MAX_SECT * SECT_BYTES + 2 * MAX_SECT * STRIDE)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                dirScatter,
  input  logic [PAGE_W-1:0]   pageSize,
  input  logic [OOB_W-1:0]    oobSize,
  output logic                done,
  output logic [SPARE_AW-1:0] spareAddr,
  output logic [7:0]          spareWdata,
  output logic                spareWe,
  input  logic [7:0]          spareRdata,
  output logic [BUF_AW-1:0]   bufAddr,
  output logic [7:0]          bufWdata,
  output logic                bufWe,
  input  logic [7:0]          bufRdata
);

  remapStrobe_t strobe;
  logic         oobZero;
  logic         lastByte;
  logic         busy;

  spareRemapCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .oobZero  (oobZero),
    .lastByte (lastByte),
    .strobe   (strobe),
    .done     (done),
    .busy     (busy)
  );

  spareRemapPath #(
    .MAX_SECT   (MAX_SECT),
    .STRIDE     (STRIDE),
    .SECT_BYTES (SECT_BYTES),
    .PAGE_W     (PAGE_W),
    .OOB_W      (OOB_W),
    .SPARE_AW   (SPARE_AW),
    .BUF_AW     (BUF_AW)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dirScatter (dirScatter),
    .pageSize   (pageSize),
    .oobSize    (oobSize),
    .oobZero    (oobZero),
    .lastByte   (lastByte),
    .spareAddr  (spareAddr),
    .spareWdata (spareWdata),
    .spareWe    (spareWe),
    .spareRdata (spareRdata),
    .bufAddr    (bufAddr),
    .bufWdata   (bufWdata),
    .bufWe      (bufWe),
    .bufRdata   (bufRdata)
  );

endmodule

// File: rtl/spareRemapChk.sv
module spareRemapChk #(
  parameter int STRIDE   = 16,
  parameter int SPARE_AW = 7,
  parameter int BUF_AW   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                done,
  input logic                busy,
  input logic                spareWe,
  input logic [SPARE_AW-1:0] spareAddr,
  input logic                bufWe,
  input logic [BUF_AW-1:0]   bufAddr
);

  // R11
  one_port_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(spareWe && bufWe));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(spareWe || bufWe));

  // R10
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spareWe || bufWe) |-> busy);

  // R6
  arr_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufWe && $past(bufWe)) |-> (bufAddr == $past(bufAddr) + 1'b1));

  // R5
  spare_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spareWe && $past(spareWe)) |->
      ((spareAddr == $past(spareAddr) + 1'b1) || ((int'(spareAddr) % STRIDE) == 0)));

endmodule

bind nandSpareRemap spareRemapChk #(
  .STRIDE   (STRIDE),
  .SPARE_AW (SPARE_AW),
  .BUF_AW   (BUF_AW)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .done      (done),
  .busy      (busy),
  .spareWe   (spareWe),
  .spareAddr (spareAddr),
  .bufWe     (bufWe),
  .bufAddr   (bufAddr)
);

// File: tb/test_nandSpareRemap.sv
module test_nandSpareRemap;

  localparam int STRIDE = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirScatter = 1'b0;
  logic [11:0] pageSize = 12'd512;
  logic [6:0]  oobSize = 7'd0;
  logic        done;
  logic [6:0]  spareAddr;
  logic [7:0]  spareWdata;
  logic        spareWe;
  logic [7:0]  spareRdata;
  logic [11:0] bufAddr;
  logic [7:0]  bufWdata;
  logic        bufWe;
  logic [7:0]  bufRdata;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic        toSpare;
    logic [11:0] addr;
    logic [7:0]  data;
  } expItem_t;

  expItem_t expQ[$];

  logic [7:0] spareMem [0:127];
  logic [7:0] bufMem   [0:4095];

  always #2.5 clk = ~clk;

  nandSpareRemap i_nandSpareRemap (
    .clk(clk), .rstN(rstN), .start(start), .dirScatter(dirScatter),
    .pageSize(pageSize), .oobSize(oobSize), .done(done),
    .spareAddr(spareAddr), .spareWdata(spareWdata), .spareWe(spareWe),
    .spareRdata(spareRdata), .bufAddr(bufAddr), .bufWdata(bufWdata),
    .bufWe(bufWe), .bufRdata(bufRdata)
  );

  // byte RAMs with one cycle read latency
  always @(posedge clk) begin
    spareRdata <= spareMem[spareAddr];
    bufRdata   <= bufMem[bufAddr];
    if (spareWe) spareMem[spareAddr] <= spareWdata;
    if (bufWe)   bufMem[bufAddr]     <= bufWdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every destination write is popped and compared
  always @(negedge clk) begin
    if (rstN && (spareWe || bufWe)) begin
      check(!(spareWe && bufWe), "R11", "both write enables", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected write addr", spareWe ? int'(spareAddr) : int'(bufAddr), -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(spareWe == e.toSpare, "R7", "write port (1=spare)", int'(spareWe), int'(e.toSpare));
        if (e.toSpare) begin
          check(spareAddr == e.addr[6:0], "R5", "spare write addr", int'(spareAddr), int'(e.addr));
          check(spareWdata == e.data, "R8", "spare write data", int'(spareWdata), int'(e.data));
        end else begin
          check(bufAddr == e.addr, "R6", "array write addr", int'(bufAddr), int'(e.addr));
          check(bufWdata == e.data, "R8", "array write data", int'(bufWdata), int'(e.data));
        end
      end
    end
  end

  // driver: fill memories, push expected writes, run one transfer
  task automatic runXfer(input bit scat, input int page, input int oob, input bit glitch);
    int n, len, idx, cyc, expCyc;
    for (int a = 0; a < 128; a++) spareMem[a] = 8'(a * 7 + oob + 3);
    for (int a = 0; a < 4096; a++) bufMem[a] = 8'(a * 13 + page / 512);
    n   = page / 512;
    len = ((oob / n) / 2) * 2;   // R3
    idx = 0;
    for (int i = 0; i < n; i++) begin
      int secLen;
      secLen = (i < n - 1) ? len : oob - (n - 1) * len;  // R4
      for (int k = 0; k < secLen; k++) begin
        expItem_t e;
        e.toSpare = scat;
        if (scat) begin
          e.addr = 12'(i * STRIDE + k);
          e.data = bufMem[page + idx];
        end else begin
          e.addr = 12'(page + idx);
          e.data = spareMem[i * STRIDE + k];
        end
        expQ.push_back(e);
        idx++;
      end
    end
    expCyc = (oob == 0) ? 1 : oob + 2;
    @(negedge clk);
    dirScatter = scat;
    pageSize   = 12'(page);
    oobSize    = 7'(oob);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 1;
    while (!done && cyc < 400) begin
      if (glitch && cyc == 3) begin
        start      = 1'b1;   // R10: must be ignored
        dirScatter = ~scat;
        pageSize   = 12'd512;
        oobSize    = 7'd16;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == expCyc, "R9", "done cycle after start", cyc, expCyc);
    check(expQ.size() == 0, "R8", "writes outstanding at done", expQ.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", int'(done), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && spareWe == 1'b0 && bufWe == 1'b0, "R1", "outputs in reset",
          int'({done, spareWe, bufWe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && spareWe == 1'b0 && bufWe == 1'b0, "R1", "outputs after reset",
          int'({done, spareWe, bufWe}), 0);
    runXfer(1'b0, 512, 16, 1'b0);   // R2 single section gather
    runXfer(1'b1, 2048, 64, 1'b0);  // R5 four full sections scatter
    runXfer(1'b0, 2048, 63, 1'b0);  // R4 long last section
    runXfer(1'b1, 1024, 5, 1'b0);   // R3 L=2, last=3
    runXfer(1'b0, 2048, 6, 1'b0);   // R3 L=0, all in last section
    runXfer(1'b0, 1024, 0, 1'b0);   // R9 empty transfer
    runXfer(1'b1, 2048, 40, 1'b1);  // R10 start mid-run ignored
    runXfer(1'b0, 1024, 32, 1'b1);  // R10 gather with glitch
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule